// File: doc/BRIEF.md
# Snooping Cache Bus-Master Request Queue

This block is the requesting side of a snooping cache controller. Miss handling logic hands it address requests: a shared-read request on a read miss, an exclusive-read request on a write miss, or a write-back that carries a line to memory. The requests wait in a request queue. The oldest request is driven onto the shared address bus together with a bus tag, and the block waits there for the address response.

A retry response rotates the request to the back of the queue, so other waiting requests get a turn. An unanimous-ok response retires the request from the queue. For a read request it also records the tag, kind and address in a pending queue that is ordered by tag. A read completes when a data-bus beat arrives whose tag matches the oldest pending entry. At that point the block drives the cache write port with the line state and the data. A beat that matches nothing is reported as a protocol error and dropped.

Top module: `snoop_master_rq`

## Requirements
- R1: After reset the block drives no address-bus request (abus_valid 0), no cache write (cw_valid 0) and no protocol error, and it accepts new requests (req_ready 1).
- R2: While the request queue holds an entry and the pending queue is not full, abus_valid is 1. The bus then carries the oldest request's kind, address, write data and the current tag, and this request stays in place until an address response arrives. Kind codes: 0 shared read, 1 exclusive read, 2 write-back.
- R3: Each unanimous-ok (aresp_valid 1, aresp_retry 0 while abus_valid) retires the head request, and the next accepted request uses a tag one higher, modulo 2^TW. The first tag after reset is 0. The tag does not move on a retry.
- R4: A retry (aresp_retry 1) moves the head request to the tail of the request queue. With A, B and C queued, a retry on A gives the bus order B, C, A.
- R5: A data beat whose tag equals the oldest pending entry's tag writes the cache in the same cycle. The write carries that entry's address and the beat data, with state 1 (Shared) for a shared read and state 2 (Exclusive) for an exclusive read. State 0 is Invalid.
- R6: Reads complete only in acceptance order. A beat whose tag is not the oldest pending tag, or that arrives while nothing is pending, raises proto_err for that cycle, makes no cache write and leaves the pending queue unchanged.
- R7: A write-back that is accepted creates no pending entry and no cache write. A later beat carrying its tag is therefore a protocol error.
- R8: While the pending queue holds OQ_DEPTH entries, no request is driven (abus_valid 0), even if requests are waiting.
- R9: req_ready is 0 while the request queue is full and in any cycle where a retry response is taken, because the retried entry uses the queue's write slot.
- R10: An unanimous-ok and a completing data beat in the same cycle both take effect: the cache write happens and the newly accepted request joins the pending queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request offered |
| req_ready | output | 1 | Request queue can take the offer |
| req_type | input | 2 | Request kind (0 shared, 1 exclusive, 2 write-back) |
| req_addr | input | AW | Line address |
| req_data | input | DW | Line data for a write-back |
| abus_valid | output | 1 | Address-bus request driven |
| abus_type | output | 2 | Kind of the driven request |
| abus_tag | output | TW | Bus tag of the driven request |
| abus_addr | output | AW | Address of the driven request |
| abus_wdata | output | DW | Write-back data of the driven request |
| aresp_valid | input | 1 | Address response present |
| aresp_retry | input | 1 | 1 retry, 0 unanimous-ok |
| dbus_valid | input | 1 | Data-bus beat present |
| dbus_tag | input | TW | Tag of the beat |
| dbus_data | input | DW | Data of the beat |
| cw_valid | output | 1 | Cache line write |
| cw_addr | output | AW | Line address written |
| cw_state | output | 2 | New line state (1 Shared, 2 Exclusive) |
| cw_data | output | DW | Line data written |
| proto_err | output | 1 | Beat with an unexpected tag |

## Verification
Two events can meet in one cycle: the address bus accepting a new request, which pushes the pending queue, and a data beat retiring the oldest pending read, which pops it. The bench fills the pending queue and then frees one slot so the waiting request is driven again. In the same cycle it returns unanimous-ok for that request and a beat for the next pending tag. The result is correct if the cache write appears with the expected address and the later beats for the remaining tags, including the one just accepted, complete in order with no protocol error.

// File: rtl/smq_pkg.sv
package smq_pkg;
   typedef enum logic [1:0] {
      RQ_SHARED = 2'd0,
      RQ_EXCL   = 2'd1,
      RQ_WB     = 2'd2
   } rq_kind_e;

   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHR = 2'd1,
      LS_EXC = 2'd2
   } line_state_e;
endpackage

// File: rtl/smq_fifo.sv
module smq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = PW + 1;
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("smq_fifo: DEPTH must be at least 1");
      end
      if (POW2) begin : g_wrap_nat
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_n;
         if (pop)  rp <= rp_n;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/smq_tag_ctr.sv
module smq_tag_ctr #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [TW-1:0] tag
);
   always_ff @(posedge clk) begin
      if (!rst_n)   tag <= '0;
      else if (adv) tag <= tag + 1'b1;
   end
endmodule

// File: rtl/smq_match.sv
module smq_match
   import smq_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          beat_valid,
   input  logic [TW-1:0] beat_tag,
   input  logic          pend_empty,
   input  logic [TW-1:0] pend_tag,
   input  logic          pend_excl,
   output logic          hit,
   output logic          miss,
   output logic [1:0]    new_state
);
   logic tag_eq;

   always_comb begin
      tag_eq    = !pend_empty && (beat_tag == pend_tag);
      hit       = beat_valid && tag_eq;
      miss      = beat_valid && !tag_eq;
      new_state = pend_excl ? LS_EXC : LS_SHR;
   end
endmodule

// File: rtl/snoop_master_rq.sv
module snoop_master_rq
   import smq_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int TW       = 4,
   parameter int RQ_DEPTH = 4,
   parameter int OQ_DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_type,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          abus_valid,
   output logic [1:0]    abus_type,
   output logic [TW-1:0] abus_tag,
   output logic [AW-1:0] abus_addr,
   output logic [DW-1:0] abus_wdata,
   input  logic          aresp_valid,
   input  logic          aresp_retry,
   input  logic          dbus_valid,
   input  logic [TW-1:0] dbus_tag,
   input  logic [DW-1:0] dbus_data,
   output logic          cw_valid,
   output logic [AW-1:0] cw_addr,
   output logic [1:0]    cw_state,
   output logic [DW-1:0] cw_data,
   output logic          proto_err
);
   localparam int RQW = 2 + AW + DW;
   localparam int OQW = TW + 1 + AW;

   generate
      if (OQ_DEPTH > (1 << TW)) begin : g_bad_tag
         $error("snoop_master_rq: tag space smaller than pending depth");
      end
      if (AW < 1 || DW < 1 || TW < 1) begin : g_bad_width
         $error("snoop_master_rq: widths must be positive");
      end
   endgenerate

   logic           rq_push, rq_pop, rq_empty, rq_full;
   logic [RQW-1:0] rq_wdata, rq_rdata;
   logic           oq_push, oq_pop, oq_empty, oq_full;
   logic [OQW-1:0] oq_wdata, oq_rdata;
   logic           resp_take, take_ok, take_retry;
   logic [1:0]     h_kind;
   logic [AW-1:0]  h_addr;
   logic [DW-1:0]  h_data;
   logic [TW-1:0]  cur_tag, p_tag;
   logic           p_excl;
   logic [AW-1:0]  p_addr;
   logic           m_hit, m_miss;
   logic [1:0]     m_state;

   assign {h_kind, h_addr, h_data} = rq_rdata;
   assign {p_tag, p_excl, p_addr}  = oq_rdata;

   always_comb begin
      abus_valid = !rq_empty && !oq_full;
      resp_take  = abus_valid && aresp_valid;
      take_ok    = resp_take && !aresp_retry;
      take_retry = resp_take && aresp_retry;
      req_ready  = !rq_full && !take_retry;
      rq_pop     = resp_take;
      rq_push    = take_retry || (req_valid && req_ready);
      rq_wdata   = take_retry ? rq_rdata : {req_type, req_addr, req_data};
      oq_push    = take_ok && (h_kind != RQ_WB);
      oq_wdata   = {cur_tag, (h_kind == RQ_EXCL), h_addr};
      oq_pop     = m_hit;
   end

   smq_fifo #(.W(RQW), .DEPTH(RQ_DEPTH)) i_req_q (
      .clk(clk), .rst_n(rst_n), .push(rq_push), .wdata(rq_wdata),
      .pop(rq_pop), .rdata(rq_rdata), .empty(rq_empty), .full(rq_full)
   );

   smq_fifo #(.W(OQW), .DEPTH(OQ_DEPTH)) i_pend_q (
      .clk(clk), .rst_n(rst_n), .push(oq_push), .wdata(oq_wdata),
      .pop(oq_pop), .rdata(oq_rdata), .empty(oq_empty), .full(oq_full)
   );

   smq_tag_ctr #(.TW(TW)) i_tag (
      .clk(clk), .rst_n(rst_n), .adv(take_ok), .tag(cur_tag)
   );

   smq_match #(.TW(TW)) i_match (
      .beat_valid(dbus_valid), .beat_tag(dbus_tag),
      .pend_empty(oq_empty), .pend_tag(p_tag), .pend_excl(p_excl),
      .hit(m_hit), .miss(m_miss), .new_state(m_state)
   );

   assign abus_type  = h_kind;
   assign abus_tag   = cur_tag;
   assign abus_addr  = h_addr;
   assign abus_wdata = h_data;
   assign cw_valid   = m_hit;
   assign cw_addr    = p_addr;
   assign cw_state   = m_state;
   assign cw_data    = dbus_data;
   assign proto_err  = m_miss;
endmodule

// File: rtl/smq_chk.sv
module smq_chk #(
   parameter int TW = 4,
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          abus_valid,
   input logic [TW-1:0] abus_tag,
   input logic [AW-1:0] abus_addr,
   input logic          aresp_valid,
   input logic          aresp_retry,
   input logic          req_ready,
   input logic          dbus_valid,
   input logic          cw_valid,
   input logic [1:0]    cw_state,
   input logic          proto_err
);
   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abus_valid && !aresp_valid) |=> (abus_valid && $stable(abus_addr)));

   // R3
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abus_valid && aresp_valid && !aresp_retry) |=> (abus_tag == TW'($past(abus_tag) + 1'b1)));

   // R3
   tag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(abus_valid && aresp_valid && !aresp_retry) |=> $stable(abus_tag));

   // R4
   retry_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abus_valid && aresp_valid && aresp_retry) |=> abus_valid);

   // R9
   retry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abus_valid && aresp_valid && aresp_retry) |-> !req_ready);

   // R5
   fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |-> (cw_state == 2'd1 || cw_state == 2'd2));

   // R6
   beat_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_valid || proto_err) |-> (dbus_valid && $onehot0({cw_valid, proto_err})));
endmodule

bind snoop_master_rq smq_chk #(.TW(TW), .AW(AW)) i_chk (
   .clk(clk), .rst_n(rst_n), .abus_valid(abus_valid), .abus_tag(abus_tag),
   .abus_addr(abus_addr), .aresp_valid(aresp_valid), .aresp_retry(aresp_retry),
   .req_ready(req_ready), .dbus_valid(dbus_valid), .cw_valid(cw_valid),
   .cw_state(cw_state), .proto_err(proto_err)
);

// File: tb/test_snoop_master_rq.sv
`timescale 1ns/1ps
module test_snoop_master_rq;
   localparam int AW = 32, DW = 32, TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_ready;
   logic [1:0]    req_type = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          abus_valid;
   logic [1:0]    abus_type;
   logic [TW-1:0] abus_tag;
   logic [AW-1:0] abus_addr;
   logic [DW-1:0] abus_wdata;
   logic          aresp_valid = 1'b0, aresp_retry = 1'b0;
   logic          dbus_valid = 1'b0;
   logic [TW-1:0] dbus_tag = '0;
   logic [DW-1:0] dbus_data = '0;
   logic          cw_valid;
   logic [AW-1:0] cw_addr;
   logic [1:0]    cw_state;
   logic [DW-1:0] cw_data;
   logic          proto_err;

   int  n_chk = 0, n_err = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   snoop_master_rq #(.AW(AW), .DW(DW), .TW(TW), .RQ_DEPTH(4), .OQ_DEPTH(4)) i_snoop_master_rq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_type(req_type), .req_addr(req_addr), .req_data(req_data),
      .abus_valid(abus_valid), .abus_type(abus_type), .abus_tag(abus_tag),
      .abus_addr(abus_addr), .abus_wdata(abus_wdata),
      .aresp_valid(aresp_valid), .aresp_retry(aresp_retry),
      .dbus_valid(dbus_valid), .dbus_tag(dbus_tag), .dbus_data(dbus_data),
      .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_state(cw_state),
      .cw_data(cw_data), .proto_err(proto_err)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_req(input logic [1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_type = t; req_addr = a; req_data = d;
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic resp(input logic rty);
      @(negedge clk);
      aresp_valid = 1'b1; aresp_retry = rty;
      @(posedge clk); #1;
      aresp_valid = 1'b0; aresp_retry = 1'b0;
   endtask

   task automatic look_head(input string req, input logic [1:0] t, input logic [AW-1:0] a, input logic [TW-1:0] tg);
      @(negedge clk); #1;
      chk(req, "abus_valid", abus_valid, 1);
      chk(req, "abus_type", abus_type, t);
      chk(req, "abus_addr", abus_addr, a);
      chk(req, "abus_tag", abus_tag, tg);
   endtask

   task automatic beat(input string req, input logic [TW-1:0] tg, input logic [DW-1:0] d,
                       input bit hit, input logic [AW-1:0] a, input logic [1:0] st);
      @(negedge clk);
      dbus_valid = 1'b1; dbus_tag = tg; dbus_data = d;
      #1;
      chk(req, "cw_valid", cw_valid, hit);
      chk(req, "proto_err", proto_err, !hit);
      if (hit) begin
         chk(req, "cw_addr", cw_addr, a);
         chk(req, "cw_state", cw_state, st);
         chk(req, "cw_data", cw_data, d);
      end
      @(posedge clk); #1;
      dbus_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk("R1", "abus_valid", abus_valid, 0);
      chk("R1", "cw_valid", cw_valid, 0);
      chk("R1", "proto_err", proto_err, 0);
      chk("R1", "req_ready", req_ready, 1);
   endtask

   task automatic t_shared_read();
      push_req(2'd0, 32'h10, 32'h0);
      look_head("R2", 2'd0, 32'h10, 4'd0);
      resp(1'b0);
      @(negedge clk); #1;
      chk("R3", "abus_valid after ok", abus_valid, 0);
      beat("R5", 4'd0, 32'hCAFE0001, 1'b1, 32'h10, 2'd1);
   endtask

   task automatic t_retry_order();
      push_req(2'd0, 32'h20, 0);
      push_req(2'd1, 32'h30, 0);
      push_req(2'd0, 32'h40, 0);
      look_head("R2", 2'd0, 32'h20, 4'd1);
      @(negedge clk);
      aresp_valid = 1'b1; aresp_retry = 1'b1;
      #1;
      chk("R9", "req_ready during retry", req_ready, 0);
      @(posedge clk); #1;
      aresp_valid = 1'b0; aresp_retry = 1'b0;
      look_head("R4", 2'd1, 32'h30, 4'd1);
      resp(1'b0);
      look_head("R4", 2'd0, 32'h40, 4'd2);
      resp(1'b0);
      look_head("R4", 2'd0, 32'h20, 4'd3);
      resp(1'b0);
      beat("R6", 4'd3, 32'h1, 1'b0, 0, 0);
      beat("R5", 4'd1, 32'hE1, 1'b1, 32'h30, 2'd2);
      beat("R6", 4'd2, 32'hE2, 1'b1, 32'h40, 2'd1);
      beat("R6", 4'd3, 32'hE3, 1'b1, 32'h20, 2'd1);
      beat("R6", 4'd3, 32'hE4, 1'b0, 0, 0);
   endtask

   task automatic t_writeback();
      push_req(2'd2, 32'h50, 32'hAB);
      look_head("R7", 2'd2, 32'h50, 4'd4);
      @(negedge clk); #1;
      chk("R7", "abus_wdata", abus_wdata, 32'hAB);
      resp(1'b0);
      beat("R7", 4'd4, 32'h77, 1'b0, 0, 0);
      push_req(2'd0, 32'h60, 0);
      look_head("R3", 2'd0, 32'h60, 4'd5);
      resp(1'b0);
      beat("R7", 4'd5, 32'h66, 1'b1, 32'h60, 2'd1);
   endtask

   task automatic t_full_and_overlap();
      for (int i = 0; i < 4; i++) push_req(2'd0, 32'h100 + i, 0);
      for (int i = 0; i < 4; i++) begin
         look_head("R8", 2'd0, 32'h100 + i, TW'(6 + i));
         resp(1'b0);
      end
      push_req(2'd1, 32'h104, 0);
      @(negedge clk); #1;
      chk("R8", "abus_valid while pending full", abus_valid, 0);
      beat("R8", 4'd6, 32'h600, 1'b1, 32'h100, 2'd1);
      look_head("R8", 2'd1, 32'h104, 4'd10);
      @(negedge clk);
      aresp_valid = 1'b1; aresp_retry = 1'b0;
      dbus_valid = 1'b1; dbus_tag = 4'd7; dbus_data = 32'h700;
      #1;
      chk("R10", "cw_valid same cycle", cw_valid, 1);
      chk("R10", "cw_addr same cycle", cw_addr, 32'h101);
      @(posedge clk); #1;
      aresp_valid = 1'b0; dbus_valid = 1'b0;
      beat("R10", 4'd8, 32'h800, 1'b1, 32'h102, 2'd1);
      beat("R10", 4'd9, 32'h900, 1'b1, 32'h103, 2'd1);
      beat("R10", 4'd10, 32'hA00, 1'b1, 32'h104, 2'd2);
      @(negedge clk); #1;
      chk("R10", "abus_valid drained", abus_valid, 0);
   endtask

   task automatic t_queue_full();
      for (int i = 0; i < 4; i++) push_req(2'd0, 32'h200 + i, 0);
      @(negedge clk); #1;
      chk("R9", "req_ready when full", req_ready, 0);
      look_head("R9", 2'd0, 32'h200, 4'd11);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_shared_read();
      t_retry_order();
      t_writeback();
      t_full_and_overlap();
      t_queue_full();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule